// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Arbiter

This block arbitrates interrupts for a small processor core. It has a fixed number of ranked slots. Slot 0 is a non-maskable software trap. The remaining slots are maskable sources, and a parameter mask marks some of them as reserved. Every live maskable slot holds a pending bit and an enable bit. An event pulse sets the pending bit, and software clears it with a clear strobe. A global enable gates all maskable slots together.

The trap keeps its own pending flag. That flag is not visible on any port. When at least one slot is eligible, the block takes the lowest-numbered eligible slot, which has the highest rank. It then pulses the acknowledge and push-request outputs for one cycle, presents the slot number as the vector index and drops the global enable. A return-from-interrupt strobe raises the global enable again.

The block does not save the program counter and holds no vector table. The core does both in response to the push request and the index.

Top module: `irq_vec_arbiter`

## Requirements
- R1: After synchronous reset, the global enable, all pending bits, all enable bits and the hidden trap flag are 0, the acknowledge and push outputs are 0, and the vector output equals IDLE_VEC (default 1).
- R2: An event pulse on a live maskable slot sets its pending bit at the next edge, whatever that slot's enable bit holds. A clear strobe resets the pending bit. If an event and a clear hit the same bit in the same cycle, the event wins.
- R3: A maskable slot is taken only when the global enable, its enable bit and its pending bit are all 1 in the cycle before the acknowledge.
- R4: When several slots are eligible, the lowest slot number wins. Slot 0 is the trap, slot 2 is the external line, slots 3 to 6 are timers T0 and T1 and the serial port, and slots 10 to 13 are the paired T2 and T3 sources.
- R5: Taking any interrupt raises the acknowledge and push outputs for exactly one cycle with the vector index, and clears the global enable in that same cycle. Hardware leaves the maskable pending bit set.
- R6: A return strobe or a set strobe raises the global enable at the next edge. If an interrupt is taken at that same edge, the global enable ends at 0.
- R7: A trap request is taken as vector 0 whatever the global enable holds, and it outranks every maskable slot. Its hidden flag clears when the trap is acknowledged, so one request produces one acknowledge.
- R8: Reserved slots (default mask 0x0382: slots 1, 7, 8, 9) and slot 0 of the maskable event input never set a pending or enable bit and never produce a request.
- R9: While nothing is taken, the acknowledge is low and the vector output holds IDLE_VEC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | NSLOT | Event pulses that set pending bits; bit 0 is ignored |
| pend_clr | input | NSLOT | Strobes that clear pending bits |
| en_wr | input | 1 | Loads the enable register from en_din |
| en_din | input | NSLOT | New enable bits |
| trap_req | input | 1 | Software trap request |
| gie_set | input | 1 | Sets the global enable |
| reti | input | 1 | Return-from-interrupt strobe; sets the global enable |
| gie_o | output | 1 | Global enable state |
| pend_o | output | NSLOT | Maskable pending bits |
| en_o | output | NSLOT | Stored enable bits |
| ack_o | output | 1 | One-cycle interrupt acknowledge |
| push_o | output | 1 | One-cycle request to push the program counter |
| vec_o | output | $clog2(NSLOT) | Winning slot index, or IDLE_VEC when idle |

## Verification
The bench builds the block with its defaults: sixteen slots, reserved mask 0x0382 and an idle index of 1. With that set-up it can reach the trap against every maskable slot, ties that reach the lowest slots 14 and 15, and all four reserved positions including the one next to the trap.

An idle index that is itself a reserved slot means a stray vector can never be confused with a real acknowledge. The directed sequences cover these cases:
- a return strobe that arrives on the same edge as a take;
- an event and a clear on the same bit in the same cycle;
- re-entry into a lower slot after the higher pending bit has been cleared.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int DEF_NSLOT = 16;
  localparam logic [DEF_NSLOT-1:0] DEF_RSVD = 16'h0382;
  localparam int DEF_IDLE = 1;

  typedef enum logic [3:0] {
    SL_TRAP    = 4'd0,
    SL_RSV_A   = 4'd1,
    SL_EXT     = 4'd2,
    SL_TMR0    = 4'd3,
    SL_TMR1_UF = 4'd4,
    SL_TMR1_CP = 4'd5,
    SL_SERIAL  = 4'd6,
    SL_RSV_B   = 4'd7,
    SL_RSV_C   = 4'd8,
    SL_RSV_D   = 4'd9,
    SL_TMR2_UF = 4'd10,
    SL_TMR2_CP = 4'd11,
    SL_TMR3_UF = 4'd12,
    SL_TMR3_CP = 4'd13,
    SL_LOW_A   = 4'd14,
    SL_LOW_B   = 4'd15
  } slot_e;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NSLOT = 16,
  parameter logic [NSLOT-1:0] RSVD_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSLOT-1:0] src_evt,
  input  logic [NSLOT-1:0] pend_clr,
  input  logic             en_wr,
  input  logic [NSLOT-1:0] en_din,
  output logic [NSLOT-1:0] pend_q,
  output logic [NSLOT-1:0] en_q
);

  // Slot 0 belongs to the trap; reserved slots hold no state.
  localparam logic [NSLOT-1:0] LIVE = ~RSVD_MASK & ~{{(NSLOT-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      // event beats clear on the same bit
      pend_q <= ((pend_q & ~pend_clr) | src_evt) & LIVE;
      if (en_wr) en_q <= en_din & LIVE;
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSLOT = 16,
  localparam int VW = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0] req,
  output logic             hit,
  output logic [VW-1:0]    idx
);

  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (req[i]) idx = VW'(i);
    end
  end

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NSLOT = DEF_NSLOT,
  parameter logic [NSLOT-1:0] RSVD_MASK = DEF_RSVD,
  parameter int IDLE_VEC = DEF_IDLE,
  localparam int VW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSLOT-1:0] src_evt,
  input  logic [NSLOT-1:0] pend_clr,
  input  logic             en_wr,
  input  logic [NSLOT-1:0] en_din,
  input  logic             trap_req,
  input  logic             gie_set,
  input  logic             reti,
  output logic             gie_o,
  output logic [NSLOT-1:0] pend_o,
  output logic [NSLOT-1:0] en_o,
  output logic             ack_o,
  output logic             push_o,
  output logic [VW-1:0]    vec_o
);

  localparam logic [VW-1:0] IDLE_IDX = VW'(IDLE_VEC);
  localparam logic [VW-1:0] TRAP_IDX = VW'(SL_TRAP);

  logic [NSLOT-1:0] pend_q, en_q, req;
  logic             gie_q, trap_q, ack_q, hit;
  logic [VW-1:0]    win_idx, vec_q;

  irq_pend_bank #(.NSLOT(NSLOT), .RSVD_MASK(RSVD_MASK)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .src_evt  (src_evt),
    .pend_clr (pend_clr),
    .en_wr    (en_wr),
    .en_din   (en_din),
    .pend_q   (pend_q),
    .en_q     (en_q)
  );

  // maskable slots need the global enable; the trap sits in slot 0 without it
  always_comb begin
    req    = pend_q & en_q & {NSLOT{gie_q}};
    req[0] = trap_q;
  end

  irq_prio_pick #(.NSLOT(NSLOT)) u_pick (
    .req (req),
    .hit (hit),
    .idx (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q  <= 1'b0;
      trap_q <= 1'b0;
      ack_q  <= 1'b0;
      vec_q  <= IDLE_IDX;
    end else begin
      ack_q <= hit;
      vec_q <= hit ? win_idx : IDLE_IDX;
      if (hit)                 gie_q <= 1'b0;
      else if (reti | gie_set) gie_q <= 1'b1;
      if (trap_req)                        trap_q <= 1'b1;
      else if (hit && win_idx == TRAP_IDX) trap_q <= 1'b0;
    end
  end

  assign gie_o  = gie_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign ack_o  = ack_q;
  assign push_o = ack_q;
  assign vec_o  = vec_q;

endmodule

// File: rtl/irq_vec_arbiter_chk.sv
module irq_vec_arbiter_chk #(
  parameter int NSLOT = 16,
  parameter logic [NSLOT-1:0] RSVD_MASK = '0,
  parameter int IDLE_VEC = 1,
  localparam int VW = $clog2(NSLOT)
) (
  input logic             clk,
  input logic             rst,
  input logic             reti,
  input logic             gie_o,
  input logic [NSLOT-1:0] pend_o,
  input logic [NSLOT-1:0] en_o,
  input logic             ack_o,
  input logic             push_o,
  input logic [VW-1:0]    vec_o
);

  logic [NSLOT-1:0] live_q, above_m;
  logic             gie_q;

  always_ff @(posedge clk) begin
    live_q <= en_o & pend_o;
    gie_q  <= gie_o;
  end

  always_comb above_m = (NSLOT'(1) << vec_o) - NSLOT'(1);

  // R3: a maskable take needs enable, pending and global enable a cycle before
  p_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (ack_o && vec_o != '0) |-> (gie_q && live_q[vec_o]));

  // R4: no higher-ranked maskable slot was eligible
  p_rank_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_o && vec_o != '0) |-> ((live_q & above_m & ~RSVD_MASK) >> 1) == '0);

  // R5: taking clears the global enable
  p_push_clears_gie_r5: assert property (@(posedge clk) disable iff (rst)
    push_o |-> !gie_o);

  // R6: a return strobe raises the enable unless a take collides
  p_reti_sets_r6: assert property (@(posedge clk) disable iff (rst)
    reti |=> (ack_o || gie_o));

  // R8: reserved slots never pend or win
  p_rsvd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ((pend_o | en_o) & RSVD_MASK) == '0 && !(ack_o && RSVD_MASK[vec_o]));

  // R9: idle vector when nothing is taken
  p_idle_vec_r9: assert property (@(posedge clk) disable iff (rst)
    !ack_o |-> vec_o == VW'(IDLE_VEC));

endmodule

bind irq_vec_arbiter irq_vec_arbiter_chk #(
  .NSLOT(NSLOT), .RSVD_MASK(RSVD_MASK), .IDLE_VEC(IDLE_VEC)
) u_chk (
  .clk(clk), .rst(rst), .reti(reti), .gie_o(gie_o), .pend_o(pend_o),
  .en_o(en_o), .ack_o(ack_o), .push_o(push_o), .vec_o(vec_o)
);

// File: tb/irq_vec_arbiter_test.sv
`timescale 1ns/1ps
module irq_vec_arbiter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_evt = '0, pend_clr = '0, en_din = '0;
  logic        en_wr = 1'b0, trap_req = 1'b0, gie_set = 1'b0, reti = 1'b0;
  logic        gie_o, ack_o, push_o;
  logic [15:0] pend_o, en_o;
  logic [3:0]  vec_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_vec_arbiter uut (
    .clk(clk), .rst(rst), .src_evt(src_evt), .pend_clr(pend_clr),
    .en_wr(en_wr), .en_din(en_din), .trap_req(trap_req), .gie_set(gie_set),
    .reti(reti), .gie_o(gie_o), .pend_o(pend_o), .en_o(en_o),
    .ack_o(ack_o), .push_o(push_o), .vec_o(vec_o)
  );

  // {trap, gie, enable[15:0], event[15:0], exp_ack, exp_vec[3:0]}
  localparam logic [38:0] TBL [0:11] = '{
    {1'b0, 1'b1, 16'hFFFF, 16'h0004, 1'b1, 4'd2},   // R4 external
    {1'b0, 1'b1, 16'hFFFF, 16'h3C00, 1'b1, 4'd10},  // R4 paired timers
    {1'b0, 1'b0, 16'hFFFF, 16'h0004, 1'b0, 4'd1},   // R3 global off
    {1'b0, 1'b1, 16'h0000, 16'hFFFF, 1'b0, 4'd1},   // R3 all masked
    {1'b0, 1'b1, 16'hFFFF, 16'h0382, 1'b0, 4'd1},   // R8 reserved only
    {1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd0},   // R7 trap, gie off
    {1'b1, 1'b1, 16'hFFFF, 16'h0004, 1'b1, 4'd0},   // R7 trap outranks
    {1'b0, 1'b1, 16'hFFFF, 16'h8000, 1'b1, 4'd15},  // R4 lowest slot
    {1'b0, 1'b1, 16'h7FFF, 16'hC000, 1'b1, 4'd14},  // R3 slot 15 masked
    {1'b0, 1'b1, 16'hFFFF, 16'h0001, 1'b0, 4'd1},   // R8 bit 0 ignored
    {1'b0, 1'b1, 16'hFFF0, 16'h0068, 1'b1, 4'd5},   // R3 slot 3 masked
    {1'b0, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 4'd1}    // R9 idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic quiet();
    src_evt = '0; pend_clr = '0; en_wr = 1'b0; en_din = '0;
    trap_req = 1'b0; gie_set = 1'b0; reti = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 gie", 32'(gie_o), 0);
    chk("R1 pend", 32'(pend_o), 0);
    chk("R1 en", 32'(en_o), 0);
    chk("R1 ack", 32'(ack_o), 0);
    chk("R1 push", 32'(push_o), 0);
    chk("R1 vec", 32'(vec_o), 1);

    // table walk
    for (int k = 0; k < 12; k++) begin
      do_reset();
      trap_req = TBL[k][38]; gie_set = TBL[k][37];
      en_wr = 1'b1; en_din = TBL[k][36:21]; src_evt = TBL[k][20:5];
      @(negedge clk);
      quiet();
      @(negedge clk);
      chk($sformatf("R3/R4/R7 table %0d ack", k), 32'(ack_o), 32'(TBL[k][4]));
      chk($sformatf("R4/R9 table %0d vec", k), 32'(vec_o), 32'(TBL[k][3:0]));
      chk($sformatf("R5 table %0d gie", k), 32'(gie_o), 32'(TBL[k][37] & ~TBL[k][4]));
    end

    // R2 pending set without enable, clear, set wins
    do_reset();
    src_evt = 16'h0404;
    @(negedge clk); quiet();
    chk("R2 set unmasked", 32'(pend_o), 32'h0404);
    @(negedge clk);
    chk("R2 no take", 32'(ack_o), 0);
    pend_clr = 16'h0404; src_evt = 16'h0400;
    @(negedge clk); quiet();
    chk("R2 set beats clear", 32'(pend_o), 32'h0400);
    pend_clr = 16'h0400;
    @(negedge clk); quiet();
    chk("R2 clear", 32'(pend_o), 0);

    // R5, R6 pulse, reti and re-entry
    do_reset();
    en_wr = 1'b1; en_din = 16'h0004; src_evt = 16'h0004; gie_set = 1'b1;
    @(negedge clk); quiet();
    @(negedge clk);
    chk("R5 ack", 32'(ack_o), 1);
    chk("R5 push", 32'(push_o), 1);
    chk("R5 vec", 32'(vec_o), 2);
    chk("R5 gie cleared", 32'(gie_o), 0);
    @(negedge clk);
    chk("R5 one-cycle ack", 32'(ack_o), 0);
    chk("R5 one-cycle push", 32'(push_o), 0);
    chk("R9 idle vec", 32'(vec_o), 1);
    chk("R5 pend kept", 32'(pend_o), 32'h0004);
    reti = 1'b1;
    @(negedge clk); quiet();
    chk("R6 reti sets gie", 32'(gie_o), 1);
    chk("R6 no ack yet", 32'(ack_o), 0);
    @(negedge clk);
    chk("R6 retaken", 32'(ack_o), 1);
    chk("R6 gie dropped", 32'(gie_o), 0);
    reti = 1'b1;
    @(negedge clk);
    chk("R6 gie back", 32'(gie_o), 1);
    @(negedge clk); quiet();
    chk("R6 collide ack", 32'(ack_o), 1);
    chk("R6 collide gie", 32'(gie_o), 0);

    // R7 trap flag clears on ack
    do_reset();
    trap_req = 1'b1;
    @(negedge clk); quiet();
    @(negedge clk);
    chk("R7 trap ack", 32'(ack_o), 1);
    chk("R7 trap vec", 32'(vec_o), 0);
    @(negedge clk);
    chk("R7 single ack", 32'(ack_o), 0);
    chk("R7 vec idle", 32'(vec_o), 1);

    // R8 reserved slots stay empty
    do_reset();
    en_wr = 1'b1; en_din = 16'hFFFF; src_evt = 16'h0383; gie_set = 1'b1;
    @(negedge clk); quiet();
    chk("R8 pend empty", 32'(pend_o), 0);
    chk("R8 en masked", 32'(en_o), 32'hFC7C);
    @(negedge clk);
    chk("R8 no ack", 32'(ack_o), 0);

    // R4 next slot after clearing winner
    do_reset();
    en_wr = 1'b1; en_din = 16'hFFFF; src_evt = 16'h1040; gie_set = 1'b1;
    @(negedge clk); quiet();
    @(negedge clk);
    chk("R4 first winner", 32'(vec_o), 6);
    pend_clr = 16'h0040; reti = 1'b1;
    @(negedge clk); quiet();
    chk("R4 gap", 32'(ack_o), 0);
    @(negedge clk);
    chk("R4 second ack", 32'(ack_o), 1);
    chk("R4 second winner", 32'(vec_o), 12);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule